// File: doc/BRIEF.md
# Six-Channel Sample Address Sequencer

This block produces the memory read addresses for six independent sample-playback voices. Each voice stores a first and a last page number. A page is 256 bytes, so a voice covers whole pages only. Once started, a voice walks a byte pointer upward from the first byte of its first page to the final byte of its last page, one byte for each memory transfer that is acknowledged. When it consumes that final byte it goes silent and raises an end-of-sample flag, unless software has masked that voice.

All voices share one memory read port. A round-robin arbiter presents one request per cycle, naming the voice and the byte address. It moves on only when the memory side acknowledges. A single key register starts or silences any group of voices in one write. The per-voice volume and pan bits and a master volume are held here and brought out to the mixer, which sits outside this block. Sample decoding also sits outside it.

Top module: `sample_seq`

## Requirements
- R1: After reset no voice is playing, mem_req is 0, end_flags is 0, master_vol is 0, and every voice's volume, left and right outputs are 0.
- R2: A write to address 0x00 acts on each voice n (0..5) whose data bit n is 1. With bit 7 = 0 the voice starts at byte address {first_page, 8'h00}. With bit 7 = 1 the voice stops at once and its flag is left unchanged.
- R3: A playing voice presents its addresses in ascending order. Each address appears exactly once per acknowledged request, from {first_page, 8'h00} to {last_page, 8'hFF}, and the voice stops after that last byte is acknowledged.
- R4: When voice n stops because its last byte was acknowledged, end_flags bit n becomes 1 in the next cycle, unless mask bit n is 1. No flag rises in a cycle that follows one without an acknowledge.
- R5: A write to address 0x02 stores data bits 5..0 as the mask and clears every flag whose data bit is 1. A flag otherwise stays set until such a write clears it.
- R6: When several voices play, grants rotate by index, starting from the voice after the one last acknowledged and wrapping from 5 to 0. A request always names a playing voice.
- R7: While mem_ack is 0, the request holds its voice and address unchanged and no address advances.
- R8: Address 0x01 bits 5..0 set master_vol. Addresses 0x08+n set voice n's left enable (bit 7), right enable (bit 6) and volume (bits 4..0). Bit 5 is ignored. Address 0x10+n sets the low byte of voice n's first page and 0x18+n its high byte. Address 0x20+n sets the low byte of the last page and 0x28+n its high byte.
- R9: If a start write to a voice lands in the same cycle as the acknowledge of that voice's last byte, the restart wins: the voice keeps playing from its first byte and its flag stays 0.
- R10: mem_req is 0 whenever no voice is playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| mem_req | output | 1 | Read request valid |
| mem_ch | output | 3 | Voice that owns the request |
| mem_addr | output | 24 | Byte address requested |
| mem_ack | input | 1 | Request accepted this cycle |
| playing | output | 6 | Per-voice playing state |
| end_flags | output | 6 | End-of-sample flags, bit n for voice n |
| master_vol | output | 6 | Master volume |
| ch_vol | output | 30 | Voice volumes, 5 bits per voice, voice 0 in the low bits |
| ch_left | output | 6 | Left enables |
| ch_right | output | 6 | Right enables |

## Verification
Two events can fall in the same cycle: a start write from the key register, and the acknowledge of the last byte of the voice that the write names. The bench lets one voice run with every request acknowledged. It watches for the negative edge at which the voice presents its final address, and raises the start write for that voice in the same cycle. After that edge the voice must still be playing, back at its first byte, with its flag clear. Any other result shows that the end-of-sample path overrode the restart.

// File: rtl/sample_seq.sv
module sample_seq #(
  parameter int NCH = 6,
  parameter int VW  = 5,
  parameter int MVW = 6,
  localparam int CW = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic               mem_req,
  output logic [CW-1:0]      mem_ch,
  output logic [23:0]        mem_addr,
  input  logic               mem_ack,
  output logic [NCH-1:0]     playing,
  output logic [NCH-1:0]     end_flags,
  output logic [MVW-1:0]     master_vol,
  output logic [NCH*VW-1:0]  ch_vol,
  output logic [NCH-1:0]     ch_left,
  output logic [NCH-1:0]     ch_right
);

  logic [15:0]    first_q [NCH];
  logic [15:0]    last_q  [NCH];
  logic [23:0]    ptr_q   [NCH];
  logic [VW-1:0]  vol_q   [NCH];
  logic [NCH-1:0] run_q, flag_q, mask_q, left_q, right_q;
  logic [MVW-1:0] mvol_q;
  logic [CW-1:0]  rr_q, gnt;
  logic [NCH-1:0] take, done, set_flag;
  int             rr_idx;

  wire xfer    = mem_req && mem_ack;
  wire wr_key  = reg_we && reg_addr == 8'h00;
  wire wr_mvol = reg_we && reg_addr == 8'h01;
  wire wr_mask = reg_we && reg_addr == 8'h02;

  always_comb begin
    gnt    = '0;
    rr_idx = 0;
    for (int k = NCH - 1; k >= 0; k--) begin
      rr_idx = (int'(rr_q) + k) % NCH;
      if (run_q[rr_idx]) gnt = CW'(rr_idx);
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      take[i]     = xfer && gnt == CW'(i);
      done[i]     = ptr_q[i] == {last_q[i], 8'hFF};
      set_flag[i] = take[i] && done[i] && !(wr_key && reg_wdata[i]) && !mask_q[i];
    end
  end

  assign mem_req    = |run_q;
  assign mem_ch     = gnt;
  assign mem_addr   = ptr_q[gnt];
  assign playing    = run_q;
  assign end_flags  = flag_q;
  assign master_vol = mvol_q;
  assign ch_left    = left_q;
  assign ch_right   = right_q;

  always_comb
    for (int i = 0; i < NCH; i++) ch_vol[i*VW +: VW] = vol_q[i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      flag_q  <= '0;
      mask_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
      mvol_q  <= '0;
      rr_q    <= '0;
      for (int i = 0; i < NCH; i++) begin
        first_q[i] <= '0;
        last_q[i]  <= '0;
        ptr_q[i]   <= '0;
        vol_q[i]   <= '0;
      end
    end else begin
      if (wr_mvol) mvol_q <= reg_wdata[MVW-1:0];
      if (wr_mask) mask_q <= reg_wdata[NCH-1:0];
      flag_q <= (flag_q & ~(wr_mask ? reg_wdata[NCH-1:0] : '0)) | set_flag;
      if (xfer) rr_q <= (gnt == CW'(NCH - 1)) ? '0 : gnt + 1'b1;
      for (int i = 0; i < NCH; i++) begin
        if (reg_we && reg_addr == 8'h08 + 8'(i)) begin
          left_q[i]  <= reg_wdata[7];
          right_q[i] <= reg_wdata[6];
          vol_q[i]   <= reg_wdata[VW-1:0];
        end
        if (reg_we && reg_addr == 8'h10 + 8'(i)) first_q[i][7:0]  <= reg_wdata;
        if (reg_we && reg_addr == 8'h18 + 8'(i)) first_q[i][15:8] <= reg_wdata;
        if (reg_we && reg_addr == 8'h20 + 8'(i)) last_q[i][7:0]   <= reg_wdata;
        if (reg_we && reg_addr == 8'h28 + 8'(i)) last_q[i][15:8]  <= reg_wdata;
        if (wr_key && reg_wdata[i]) begin
          run_q[i] <= !reg_wdata[7];
          if (!reg_wdata[7]) ptr_q[i] <= {first_q[i], 8'h00};
        end else if (take[i]) begin
          if (done[i]) run_q[i] <= 1'b0;
          else         ptr_q[i] <= ptr_q[i] + 24'd1;
        end
      end
    end
  end

endmodule

module sample_seq_chk #(
  parameter int NCH = 6,
  parameter int CW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_we,
  input logic [7:0]     reg_addr,
  input logic [7:0]     reg_wdata,
  input logic           mem_req,
  input logic [CW-1:0]  mem_ch,
  input logic [23:0]    mem_addr,
  input logic           mem_ack,
  input logic [NCH-1:0] playing,
  input logic [NCH-1:0] end_flags
);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !reg_we |=> mem_req && $stable(mem_ch) && $stable(mem_addr));

  assert_grant_playing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(mem_ch) < NCH) && ((playing >> mem_ch) & NCH'(1)) != '0);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    playing == '0 |-> !mem_req);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 8'h02) |=> (end_flags & $past(end_flags)) == $past(end_flags));

  assert_flag_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ack) |=> (end_flags & ~$past(end_flags)) == '0);

  assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 8'h00 && reg_wdata[7]
      |=> (playing & $past(reg_wdata[NCH-1:0])) == '0);

endmodule

bind sample_seq sample_seq_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_ch(mem_ch),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .playing(playing),
  .end_flags(end_flags)
);

// File: tb/sample_seq_bench.sv
module sample_seq_bench;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = 0, reg_wdata = 0;
  logic        ack_en = 0;
  logic        mem_req, mem_ack;
  logic [2:0]  mem_ch;
  logic [23:0] mem_addr;
  logic [5:0]  playing, end_flags, ch_left, ch_right;
  logic [5:0]  master_vol;
  logic [29:0] ch_vol;

  int checks = 0, errors = 0, cycles = 0, nlog = 0;
  bit logging = 0, finished = 0;
  logic [2:0]  log_ch   [1024];
  logic [23:0] log_addr [1024];

  assign mem_ack = ack_en;

  sample_seq u_sample_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_ch(mem_ch),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .playing(playing),
    .end_flags(end_flags), .master_vol(master_vol), .ch_vol(ch_vol),
    .ch_left(ch_left), .ch_right(ch_right)
  );

  always #5 clk = ~clk;

  always @(negedge clk)
    if (logging && mem_req && mem_ack && nlog < 1024) begin
      log_ch[nlog]   = mem_ch;
      log_addr[nlog] = mem_addr;
      nlog++;
    end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0;
  endtask

  task automatic set_pages(input int ch, input logic [15:0] first, input logic [15:0] last);
    wr(8'h10 + 8'(ch), first[7:0]);
    wr(8'h18 + 8'(ch), first[15:8]);
    wr(8'h20 + 8'(ch), last[7:0]);
    wr(8'h28 + 8'(ch), last[15:8]);
  endtask

  task automatic wait_quiet();
    for (int n = 0; n < 2000 && playing != 0; n++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_req == 0, "R1 mem_req", mem_req, 0);
    chk(playing == 0 && end_flags == 0, "R1 playing/flags", {playing, end_flags}, 0);
    chk(master_vol == 0 && ch_vol == 0 && ch_left == 0 && ch_right == 0,
        "R1 volumes", ch_vol, 0);
    chk(mem_req == 0, "R10 idle no request", mem_req, 0);
  endtask

  task automatic t_config();
    wr(8'h01, 8'hFF);
    @(negedge clk);
    chk(master_vol == 6'h3F, "R8 master_vol", master_vol, 6'h3F);
    wr(8'h0A, 8'hE7);
    wr(8'h0B, 8'h5F);
    @(negedge clk);
    chk(ch_vol[10 +: 5] == 5'h07 && ch_left[2] && ch_right[2], "R8 voice2 vol/pan",
        {ch_left[2], ch_right[2], ch_vol[10 +: 5]}, {2'b11, 5'h07});
    chk(ch_vol[15 +: 5] == 5'h1F && !ch_left[3] && ch_right[3], "R8 voice3 vol/pan",
        {ch_left[3], ch_right[3], ch_vol[15 +: 5]}, {2'b01, 5'h1F});
  endtask

  task automatic t_single();
    int bad = 0;
    set_pages(0, 16'h0012, 16'h0012);
    ack_en = 1; nlog = 0; logging = 1;
    wr(8'h00, 8'h01);
    wait_quiet();
    logging = 0;
    chk(nlog == 256, "R3 byte count voice0", nlog, 256);
    for (int k = 0; k < 256; k++)
      if (log_ch[k] != 0 || log_addr[k] != 24'h001200 + 24'(k)) bad++;
    chk(bad == 0, "R2 R3 ascending addresses from first page", bad, 0);
    chk(playing[0] == 0, "R3 voice0 stopped", playing, 0);
    chk(end_flags == 6'h01, "R4 flag voice0", end_flags, 6'h01);
    chk(mem_req == 0, "R10 no request after stop", mem_req, 0);
  endtask

  task automatic t_rr();
    int bad = 0;
    set_pages(1, 16'h0100, 16'h0100);
    set_pages(3, 16'h0300, 16'h0300);
    nlog = 0; logging = 1;
    wr(8'h00, 8'h0A);
    wait_quiet();
    logging = 0;
    chk(nlog == 512, "R6 two-voice byte count", nlog, 512);
    for (int k = 0; k < 512; k++) begin
      logic [2:0]  ec = (k % 2 == 0) ? 3'd1 : 3'd3;
      logic [23:0] ea = ((k % 2 == 0) ? 24'h010000 : 24'h030000) + 24'(k / 2);
      if (log_ch[k] != ec || log_addr[k] != ea) bad++;
    end
    chk(bad == 0, "R6 alternating grants", bad, 0);
    chk(end_flags == 6'h0B, "R4 flags voices 0,1,3", end_flags, 6'h0B);
  endtask

  task automatic t_hold_and_dump();
    int bad = 0;
    ack_en = 0;
    set_pages(2, 16'h0200, 16'h0201);
    wr(8'h00, 8'h04);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!mem_req || mem_ch != 2 || mem_addr != 24'h020000) bad++;
    end
    chk(bad == 0, "R7 request held without ack", mem_addr, 24'h020000);
    @(posedge clk); #2 ack_en = 1;
    repeat (3) @(posedge clk);
    #2 ack_en = 0;
    @(negedge clk);
    chk(mem_addr == 24'h020003, "R7 advance per ack", mem_addr, 24'h020003);
    wr(8'h00, 8'h84);
    @(negedge clk);
    chk(playing[2] == 0 && mem_req == 0, "R2 dump stops voice2", playing, 0);
    chk(end_flags == 6'h0B, "R2 dump leaves flags", end_flags, 6'h0B);
  endtask

  task automatic t_mask();
    wr(8'h02, 8'h11);
    @(negedge clk);
    chk(end_flags == 6'h0A, "R5 clear flag0", end_flags, 6'h0A);
    set_pages(4, 16'h0400, 16'h0400);
    ack_en = 1;
    wr(8'h00, 8'h10);
    wait_quiet();
    chk(playing[4] == 0, "R3 masked voice still stops", playing, 0);
    chk(end_flags == 6'h0A, "R4 masked voice4 no flag", end_flags, 6'h0A);
    wr(8'h02, 8'h00);
    @(negedge clk);
    chk(end_flags == 6'h0A, "R5 zero write keeps flags", end_flags, 6'h0A);
    wr(8'h02, 8'h0A);
    wr(8'h02, 8'h00);
    @(negedge clk);
    chk(end_flags == 6'h00, "R5 clear flags 1,3", end_flags, 0);
  endtask

  task automatic t_collide();
    int n;
    set_pages(5, 16'h0030, 16'h0030);
    ack_en = 1;
    wr(8'h00, 8'h20);
    for (n = 0; n < 1000; n++) begin
      @(negedge clk);
      if (mem_req && mem_ch == 5 && mem_addr == 24'h0030FF) break;
    end
    reg_we = 1; reg_addr = 8'h00; reg_wdata = 8'h20;
    @(posedge clk); #2 reg_we = 0;
    @(negedge clk);
    chk(playing[5] == 1, "R9 restart wins over end", playing, 6'h20);
    chk(mem_addr == 24'h003000, "R9 back at first byte", mem_addr, 24'h003000);
    chk(end_flags[5] == 0, "R9 no flag on restart", end_flags, 0);
    wr(8'h00, 8'hA0);
    @(negedge clk);
    chk(playing == 0 && end_flags == 0, "R2 stop voice5 no flag", {playing, end_flags}, 0);
    chk(mem_req == 0, "R10 idle after stop", mem_req, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_config();
    t_single();
    t_rr();
    t_hold_and_dump();
    t_mask();
    t_collide();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule